// File: doc/BRIEF.md
# Intra DC Predictor and Reconstructor

This block turns decoded DC differences back into absolute quantized DC coefficients for intra-coded 8x8 blocks of a video decoder. It holds one running predictor for each of three colour components (luma and two chroma). For every accepted difference it adds the signed value to the predictor of the chosen component. It presents the sum one cycle later, and the same sum becomes that component's new predictor.

Three event inputs return all predictors to a start value: the start of a slice, a non-intra macroblock and a skipped macroblock. The start value follows a 2-bit DC precision code. The entropy decoder in front supplies the differences. The inverse quantizer behind it consumes the reconstructed values.

Top module: `dc_pred_recon`

## Requirements
- R1: The three predictors are independent: an operation on one component leaves the predictors of the other two unchanged.
- R2: The reconstructed value is the selected predictor plus `diff_i`, read as a two's-complement signed number, with the sum taken modulo 2^DC_W.
- R3: An accepted input (`valid_i` high with `comp_sel_i` of 0, 1 or 2) raises `dc_valid_o` for exactly the next cycle, with the result on `dc_o`. In every other cycle `dc_valid_o` is low and `dc_o` keeps its last value.
- R4: Each result is written back as the new predictor of its component, so back-to-back inputs on one component chain without gaps.
- R5: A pulse on `slice_start_i` sets all three predictors to the start value.
- R6: A pulse on `non_intra_i` or on `skip_i` sets all three predictors to the start value.
- R7: The start value is 128 shifted left by `dc_prec_i`: codes 0, 1, 2 and 3 give 128, 256, 512 and 1024.
- R8: When a reset event and an accepted input fall in the same cycle, the reset is applied first. The input then adds to the start value, and the other two components are left at the start value.
- R9: An input with `comp_sel_i` equal to 3 is ignored. It produces no output and changes no predictor.
- R10: While `rst_ni` is low, `dc_valid_o` and `dc_o` are 0 and every predictor is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slice_start_i | input | 1 | New slice: reset predictors |
| non_intra_i | input | 1 | Non-intra macroblock: reset predictors |
| skip_i | input | 1 | Skipped macroblock: reset predictors |
| dc_prec_i | input | 2 | DC precision code, selects the start value |
| valid_i | input | 1 | Difference valid strobe |
| comp_sel_i | input | 2 | Component: 0 luma, 1 and 2 chroma, 3 invalid |
| diff_i | input | 12 | Signed DC difference |
| dc_valid_o | output | 1 | Result valid |
| dc_o | output | 12 | Reconstructed DC value |

## Verification
The bench builds the block with its defaults: 12-bit differences and results, and three components behind a 2-bit select. With these widths the unused select code 3 can be driven, so the ignore path gets exercised. The largest start value, 1024, pushed by large negative and positive differences, wraps the 12-bit sum in both directions. All four precision codes fit in the bench, so every start value is checked, including resets that fall in the same cycle as a difference.

// File: rtl/dc_pred_pkg.sv
package dc_pred_pkg;
  localparam int unsigned BASE_LOG2 = 7;  // start value for precision code 0 is 2**7
  localparam int unsigned PREC_W    = 2;
endpackage

// File: rtl/dc_rst_val.sv
module dc_rst_val
  import dc_pred_pkg::*;
#(
  parameter int unsigned DC_W = 12
) (
  input  logic [PREC_W-1:0] prec_i,
  output logic [DC_W-1:0]   val_o
);
  localparam int unsigned NUM_PREC = 1 << PREC_W;

  logic [NUM_PREC-1:0][DC_W-1:0] table_w;

  for (genvar p = 0; p < NUM_PREC; p++) begin : g_tab
    assign table_w[p] = DC_W'(1) << (BASE_LOG2 + p);
  end

  assign val_o = table_w[prec_i];
endmodule

// File: rtl/dc_recon_add.sv
module dc_recon_add #(
  parameter int unsigned DC_W   = 12,
  parameter int unsigned DIFF_W = 12
) (
  input  logic [DC_W-1:0]   pred_i,
  input  logic [DIFF_W-1:0] diff_i,
  output logic [DC_W-1:0]   sum_o
);
  localparam int unsigned SUM_W = (DC_W > DIFF_W) ? DC_W : DIFF_W;

  logic [SUM_W-1:0] ext_pred;
  logic [SUM_W-1:0] ext_diff;
  logic [SUM_W-1:0] sum_full;

  assign ext_pred = SUM_W'(pred_i);
  assign ext_diff = SUM_W'($signed(diff_i));
  assign sum_full = ext_pred + ext_diff;
  assign sum_o    = sum_full[DC_W-1:0];
endmodule

// File: rtl/dc_pred_bank.sv
module dc_pred_bank #(
  parameter int unsigned DC_W     = 12,
  parameter int unsigned NUM_COMP = 3,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned INIT_VAL = 128
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic [DC_W-1:0]               clr_val_i,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_sel_i,
  input  logic [DC_W-1:0]               wr_data_i,
  output logic [NUM_COMP-1:0][DC_W-1:0] pred_o
);
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pred_o[k] <= DC_W'(INIT_VAL);
      else if (hit) pred_o[k] <= wr_data_i;  // write wins over clear: sum already used clear value
      else if (clr_i) pred_o[k] <= clr_val_i;
    end
  end
endmodule

// File: rtl/dc_pred_recon.sv
module dc_pred_recon
  import dc_pred_pkg::*;
#(
  parameter int unsigned DC_W     = 12,
  parameter int unsigned DIFF_W   = 12,
  parameter int unsigned NUM_COMP = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slice_start_i,
  input  logic              non_intra_i,
  input  logic              skip_i,
  input  logic [PREC_W-1:0] dc_prec_i,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  comp_sel_i,
  input  logic [DIFF_W-1:0] diff_i,
  output logic              dc_valid_o,
  output logic [DC_W-1:0]   dc_o
);
  localparam int unsigned INIT_VAL = 1 << BASE_LOG2;

  logic                          clr;
  logic                          sel_ok;
  logic                          accept;
  logic [DC_W-1:0]               rst_val;
  logic [NUM_COMP-1:0][DC_W-1:0] pred;
  logic [DC_W-1:0]               pred_sel;
  logic [DC_W-1:0]               base;
  logic [DC_W-1:0]               sum;

  assign clr    = slice_start_i | non_intra_i | skip_i;
  assign sel_ok = {1'b0, comp_sel_i} < (SEL_W + 1)'(NUM_COMP);
  assign accept = valid_i && sel_ok;

  dc_rst_val #(.DC_W(DC_W)) u_rst_val (
    .prec_i (dc_prec_i),
    .val_o  (rst_val)
  );

  always_comb begin
    pred_sel = '0;
    for (int k = 0; k < NUM_COMP; k++) begin
      if (comp_sel_i == SEL_W'(k)) pred_sel = pred[k];
    end
  end

  assign base = clr ? rst_val : pred_sel;  // reset precedes the add

  dc_recon_add #(.DC_W(DC_W), .DIFF_W(DIFF_W)) u_add (
    .pred_i (base),
    .diff_i (diff_i),
    .sum_o  (sum)
  );

  dc_pred_bank #(
    .DC_W     (DC_W),
    .NUM_COMP (NUM_COMP),
    .SEL_W    (SEL_W),
    .INIT_VAL (INIT_VAL)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .clr_val_i (rst_val),
    .wr_en_i   (accept),
    .wr_sel_i  (comp_sel_i),
    .wr_data_i (sum),
    .pred_o    (pred)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_valid_o <= 1'b0;
      dc_o       <= '0;
    end else begin
      dc_valid_o <= accept;
      if (accept) dc_o <= sum;
    end
  end
endmodule

// File: rtl/dc_pred_recon_sva.sv
module dc_pred_recon_sva
  import dc_pred_pkg::*;
#(
  parameter int unsigned DC_W     = 12,
  parameter int unsigned DIFF_W   = 12,
  parameter int unsigned NUM_COMP = 3,
  parameter int unsigned SEL_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slice_start_i,
  input logic              non_intra_i,
  input logic              skip_i,
  input logic [PREC_W-1:0] dc_prec_i,
  input logic              valid_i,
  input logic [SEL_W-1:0]  comp_sel_i,
  input logic [DIFF_W-1:0] diff_i,
  input logic              dc_valid_o,
  input logic [DC_W-1:0]   dc_o
);
  logic            evt;
  logic            good_sel;
  logic [DC_W-1:0] start_plus_diff;

  assign evt             = slice_start_i | non_intra_i | skip_i;
  assign good_sel        = int'(comp_sel_i) < NUM_COMP;
  assign start_plus_diff = DC_W'((128 << dc_prec_i) + int'($signed(diff_i)));

  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && good_sel) |=> dc_valid_o);  // R3

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!dc_valid_o && $stable(dc_o)));  // R3

  AST_BAD_SEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !good_sel) |=> !dc_valid_o);  // R9

  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && valid_i && good_sel) |=> (dc_o == $past(start_plus_diff)));  // R8

  AST_CHAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && good_sel && !evt && diff_i == '0 && $past(valid_i)
     && $past(comp_sel_i) == comp_sel_i) |=> (dc_o == $past(dc_o)));  // R4

  AST_NO_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({dc_valid_o, dc_o}));  // R3
endmodule

bind dc_pred_recon dc_pred_recon_sva #(
  .DC_W(DC_W), .DIFF_W(DIFF_W), .NUM_COMP(NUM_COMP), .SEL_W(SEL_W)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .slice_start_i (slice_start_i),
  .non_intra_i   (non_intra_i),
  .skip_i        (skip_i),
  .dc_prec_i     (dc_prec_i),
  .valid_i       (valid_i),
  .comp_sel_i    (comp_sel_i),
  .diff_i        (diff_i),
  .dc_valid_o    (dc_valid_o),
  .dc_o          (dc_o)
);

// File: tb/dc_pred_recon_tb.sv
module dc_pred_recon_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slice_start_i = 1'b0;
  logic        non_intra_i = 1'b0;
  logic        skip_i = 1'b0;
  logic [1:0]  dc_prec_i = 2'd0;
  logic        valid_i = 1'b0;
  logic [1:0]  comp_sel_i = 2'd0;
  logic [11:0] diff_i = 12'd0;
  logic        dc_valid_o;
  logic [11:0] dc_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    run = 1'b0;
  string cur_tag = "R10";
  string tag_q = "R10";

  int m_pred[3];
  bit m_valid;
  int m_dc;

  always #2 clk_i = ~clk_i;

  dc_pred_recon u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slice_start_i (slice_start_i),
    .non_intra_i   (non_intra_i),
    .skip_i        (skip_i),
    .dc_prec_i     (dc_prec_i),
    .valid_i       (valid_i),
    .comp_sel_i    (comp_sel_i),
    .diff_i        (diff_i),
    .dc_valid_o    (dc_valid_o),
    .dc_o          (dc_o)
  );

  // behavioural reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 3; k++) m_pred[k] = 128;
      m_valid = 1'b0;
      m_dc    = 0;
    end else begin
      if (slice_start_i || non_intra_i || skip_i)
        for (int k = 0; k < 3; k++) m_pred[k] = 128 << dc_prec_i;
      m_valid = valid_i && (comp_sel_i != 2'd3);
      if (m_valid) begin
        m_dc = (m_pred[comp_sel_i] + int'($signed(diff_i))) & 12'hFFF;
        m_pred[comp_sel_i] = m_dc;
      end
      tag_q = cur_tag;
    end
  end

  always @(negedge clk_i) begin
    if (run) begin
      n_cmp++;
      if (dc_valid_o !== m_valid || dc_o !== 12'(m_dc)) begin
        n_bad++;
        $display("FAIL %s: valid=%0b dc=%0d expected valid=%0b dc=%0d",
                 tag_q, dc_valid_o, dc_o, m_valid, m_dc);
      end
    end
  end

  task automatic op(input string tag, input bit v, input int sel, input int d,
                    input bit ss = 0, input bit ni = 0, input bit sk = 0, input int pr = 0);
    cur_tag       = tag;
    valid_i       = v;
    comp_sel_i    = 2'(sel);
    diff_i        = 12'(d);
    slice_start_i = ss;
    non_intra_i   = ni;
    skip_i        = sk;
    dc_prec_i     = 2'(pr);
    @(negedge clk_i);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R10 reset state at the ports
    n_cmp++;
    if (dc_valid_o !== 1'b0 || dc_o !== 12'd0) begin
      n_bad++;
      $display("FAIL R10: valid=%0b dc=%0d expected valid=0 dc=0", dc_valid_o, dc_o);
    end
    rst_ni = 1'b1;
    run = 1'b1;
    op("R10", 1, 0, 0);          // 128
    op("R2", 1, 1, 5);           // 133
    op("R2", 1, 2, -3);          // 125
    op("R4", 1, 0, 10);          // 138
    op("R4", 1, 0, 10);          // 148
    op("R1", 1, 1, 0);           // 133
    op("R3", 0, 0, 77);
    op("R3", 0, 2, 5);
    op("R9", 1, 3, 100);
    op("R9", 1, 0, 0);           // 148
    op("R2", 1, 2, -200);        // wraps to 4021
    op("R2", 1, 2, 2047);        // 6068 mod 4096
    op("R5", 0, 0, 0, 1, 0, 0, 2);
    op("R7", 1, 0, 0);           // 512
    op("R7", 1, 1, 0);
    op("R7", 1, 2, 0);
    op("R6", 0, 0, 0, 0, 1, 0, 3);
    op("R7", 1, 2, 0);           // 1024
    op("R2", 1, 2, 2047);        // 3071
    op("R2", 1, 2, 2047);        // wraps
    op("R6", 0, 0, 0, 0, 0, 1, 1);
    op("R7", 1, 1, -1);          // 255
    op("R8", 1, 1, 7, 1, 0, 0, 0);   // 135
    op("R8", 1, 0, 0);           // 128
    op("R8", 1, 2, 0);           // 128
    op("R8", 1, 0, -5, 0, 1, 0, 2);  // 507
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      op("R2", $urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 4095),
         r == 0, r == 1, r == 2, $urandom_range(0, 3));
    end
    op("R3", 0, 0, 0);
    run = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule